// File: doc/BRIEF.md
# Fill-then-verify memory device tester

This engine checks that a memory device is really present and storing data. It is meant to run after the data-line and address-line checks have passed. In the first phase it writes a distinct value to every location of an address window. The value for location number k (counting from zero at the lower bound) is k+1. Only when the last location has been written does the second phase begin. That phase reads the window back, lowest address first, and compares each word against the value written there.

Because the two phases never interleave, a device that is absent cannot pass by accident. On such a bus the first read returns whatever the bus still holds from the last write, and that value differs from the one expected at the first location. The engine stops at the first mismatch. It reports the address, the expected word and the observed word, and pulses `done`. A clean run pulses `done` with `pass` set.

The memory port is a plain synchronous command port with no back-pressure. The device accepts a request on every cycle in which `mem_req` is high. Read data is taken exactly `RD_LAT` cycles after the read request, and only one read is outstanding at a time.

Top module: `memfill_tester`

## Requirements
- R1: A `start` pulse while `prereq_ok` is low is ignored: no memory request is issued, `busy` stays low and `done` does not pulse.
- R2: If `start` is accepted with `hi_addr` < `lo_addr`, then in the next cycle `done` pulses with `range_err`=1, `pass`=0 and `fail`=0, and no memory request is made.
- R3: During the fill phase the engine issues one write per cycle at addresses `lo_addr`, `lo_addr`+1, … up to `hi_addr`. The data for location k is (k+1) modulo 2^DATA_W.
- R4: No read request is issued before every address in the window has been written.
- R5: Verify reads run in ascending address order, starting at `lo_addr`, one address per read.
- R6: `mem_rdata` is sampled exactly `RD_LAT` cycles after the read request. No new request is issued while a read is outstanding.
- R7: If every location matches, `done` pulses once with `pass`=1 and `fail`=0.
- R8: At the first mismatch the engine stops reading and pulses `done` with `fail`=1. `fail_addr`, `fail_exp` and `fail_obs` then hold the failing address, the expected word and the read word.
- R9: If the bus only echoes the last written word (absent device), a window of two or more locations fails at `lo_addr`. In that case `fail_exp`=1 and `fail_obs` equals the last value written.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `done` pulses. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a test run |
| prereq_ok | input | 1 | Earlier bus tests passed; gates `start` |
| lo_addr | input | ADDR_W | First address of the window, latched at start |
| hi_addr | input | ADDR_W | Last address of the window, latched at start |
| mem_req | output | 1 | Memory command valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after a read |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run passed |
| fail | output | 1 | Last run found a mismatch |
| range_err | output | 1 | Last start had an inverted window |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_exp | output | DATA_W | Expected word at that address |
| fail_obs | output | DATA_W | Word actually read |

## Verification
Suppose the address/value counter is corrupted or a phase ends early. The request stream on the memory port shows it within a cycle: a skipped address, a wrong data word, or a read placed before the last write. The bench watches that stream against the window it chose. A latency counter that is off by one shows up on the first read. The engine compares against a stale word, so it reports a false `fail` at `lo_addr`, or passes when the absent-device mode should fail. A wrong stop condition shows up at `done`: the number of reads issued differs from the failing position.

// File: rtl/memfill_pkg.sv
package memfill_pkg;
  typedef enum logic [1:0] {
    MF_IDLE  = 2'd0,
    MF_FILL  = 2'd1,
    MF_ISSUE = 2'd2,
    MF_WAIT  = 2'd3
  } mf_state_e;
endpackage

// File: rtl/memfill_seq.sv
// Address pointer and pattern value that advance together.
module memfill_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      value <= '0;
    end else if (load) begin
      addr  <= base;
      value <= DATA_W'(1);
    end else if (step) begin
      addr  <= addr + ADDR_W'(1);
      value <= value + DATA_W'(1);
    end
  end
endmodule

// File: rtl/memfill_lat.sv
// Counts cycles since a read request; flags the sampling cycle.
module memfill_lat #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expired
);
  localparam int CW = $clog2(RD_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(RD_LAT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (arm) begin
      cnt <= CW'(1);
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expired = (cnt == LAST);
endmodule

// File: rtl/memfill_tester.sv
module memfill_tester #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              prereq_ok,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              range_err,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);
  import memfill_pkg::*;

  mf_state_e         state;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] pat;
  logic              accept, seq_load, seq_step, at_end, expired, mismatch;
  logic [ADDR_W-1:0] seq_base;

  assign accept   = (state == MF_IDLE) && start && prereq_ok;
  assign at_end   = (ptr == hi_q);
  assign mismatch = (mem_rdata != pat);

  // load at accepted start (from inputs) and at fill->verify turn (latched)
  assign seq_load = (accept && !(hi_addr < lo_addr)) ||
                    ((state == MF_FILL) && at_end);
  assign seq_base = (state == MF_IDLE) ? lo_addr : lo_q;
  assign seq_step = ((state == MF_FILL) && !at_end) ||
                    ((state == MF_WAIT) && expired && !mismatch && !at_end);

  memfill_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .step(seq_step),
    .base(seq_base), .addr(ptr), .value(pat)
  );

  memfill_lat #(.RD_LAT(RD_LAT)) lat_i (
    .clk(clk), .rst_n(rst_n), .arm(state == MF_ISSUE), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= MF_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      range_err <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        MF_IDLE: begin
          if (accept) begin
            pass <= 1'b0;
            fail <= 1'b0;
            if (hi_addr < lo_addr) begin
              range_err <= 1'b1;
              done      <= 1'b1;
            end else begin
              range_err <= 1'b0;
              lo_q      <= lo_addr;
              hi_q      <= hi_addr;
              state     <= MF_FILL;
            end
          end
        end
        MF_FILL: begin
          if (at_end) state <= MF_ISSUE;
        end
        MF_ISSUE: state <= MF_WAIT;
        MF_WAIT: begin
          if (expired) begin
            if (mismatch) begin
              fail      <= 1'b1;
              fail_addr <= ptr;
              fail_exp  <= pat;
              fail_obs  <= mem_rdata;
              done      <= 1'b1;
              state     <= MF_IDLE;
            end else if (at_end) begin
              pass  <= 1'b1;
              done  <= 1'b1;
              state <= MF_IDLE;
            end else begin
              state <= MF_ISSUE;
            end
          end
        end
        default: state <= MF_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == MF_FILL) || (state == MF_ISSUE);
  assign mem_we    = (state == MF_FILL);
  assign mem_addr  = ptr;
  assign mem_wdata = pat;
  assign busy      = (state != MF_IDLE);
endmodule

// File: rtl/memfill_tester_chk.sv
module memfill_tester_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              range_err
);
  logic seen_read;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_read <= 1'b0;
    else if (done) seen_read <= 1'b0;
    else if (mem_req && !mem_we) seen_read <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_range_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |-> (!pass && !fail));

  assert_fill_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req) && $past(mem_we))
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_fill_before_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !seen_read);

  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  assert_verdict_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(pass && fail));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind memfill_tester memfill_tester_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .range_err(range_err)
);

// File: tb/memfill_tester_tb_top.sv
module memfill_tester_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, prereq_ok = 1'b0;
  logic [AW-1:0] lo_addr = '0, hi_addr = '0;
  logic mem_req, mem_we, busy, done, pass, fail, range_err;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_obs;

  always #4 clk = ~clk;

  memfill_tester #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prereq_ok(prereq_ok),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .range_err(range_err),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs)
  );

  // memory model: mode 0 healthy, 1 absent (bus echo), 2 bit 0 flipped at bad_a
  int unsigned mode = 0;
  logic [AW-1:0] bad_a = '0;
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] bus_q = '0;
  logic [DW-1:0] rpipe [LAT];
  assign mem_rdata = rpipe[LAT-1];

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr] <= (mode == 2 && mem_addr == bad_a) ? (mem_wdata ^ DW'(1)) : mem_wdata;
      bus_q <= mem_wdata;
    end
    rpipe[0] <= (mode == 1) ? bus_q : mem[mem_addr];
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
  end

  // port monitor
  int unsigned wr_n, rd_n, wr_bad, rd_bad, req_cnt, exp_size;
  logic [AW-1:0] mon_lo;
  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      req_cnt++;
      if (mem_we) begin
        if (rd_n != 0 || mem_addr != AW'(mon_lo + wr_n) || mem_wdata != DW'(wr_n + 1)) wr_bad++;
        wr_n++;
      end else begin
        if (wr_n != exp_size || mem_addr != AW'(mon_lo + rd_n)) rd_bad++;
        rd_n++;
      end
    end
  end

  int checks = 0, failures = 0;
  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned fail_pos(int unsigned m, int unsigned lo, int unsigned hi, int unsigned bad);
    int unsigned sz = hi - lo + 1;
    if (m == 1 && (sz % (2**DW)) != 1) return 0;
    if (m == 2 && bad >= lo && bad <= hi) return bad - lo;
    return sz; // sz means no failure
  endfunction

  task automatic run_test(input int unsigned lo, input int unsigned hi,
                          input int unsigned m, input int unsigned bad);
    int unsigned sz = hi - lo + 1;
    int unsigned fp = fail_pos(m, lo, hi, bad);
    bit got = 0;
    mode = m; bad_a = AW'(bad);
    wr_n = 0; rd_n = 0; wr_bad = 0; rd_bad = 0; exp_size = sz; mon_lo = AW'(lo);
    @(negedge clk);
    lo_addr = AW'(lo); hi_addr = AW'(hi); prereq_ok = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    for (int i = 0; i < 4000 && !got; i++) begin
      if (done) got = 1; else @(negedge clk);
    end
    chk(got, "R10 done pulse", got, 1);
    chk(wr_n == sz && wr_bad == 0, "R3 fill sequence", wr_bad, 0);
    chk(rd_bad == 0, "R4 R5 read order", rd_bad, 0);
    if (fp == sz) begin
      chk(pass && !fail, "R7 verdict pass", {pass, fail}, 2);
      chk(rd_n == sz, "R7 read count", rd_n, sz);
    end else begin
      chk(fail && !pass, "R8 verdict fail", {pass, fail}, 1);
      chk(fail_addr == AW'(lo + fp), "R8 fail_addr", fail_addr, AW'(lo + fp));
      chk(fail_exp == DW'(fp + 1), "R8 fail_exp", fail_exp, DW'(fp + 1));
      if (m == 1)
        chk(fail_obs == DW'(sz), "R9 echoed last value", fail_obs, DW'(sz));
      else
        chk(fail_obs == DW'((fp + 1) ^ 1), "R8 fail_obs", fail_obs, DW'((fp + 1) ^ 1));
      chk(rd_n == fp + 1, "R8 stop after mismatch", rd_n, fp + 1);
    end
    @(negedge clk);
    chk(!busy && !done, "R10 back to idle", {busy, done}, 0);
  endtask

  int unsigned cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R10 watchdog act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !pass && !fail && !range_err,
        "R10 reset state", {busy, done, mem_req, pass, fail, range_err}, 0);

    // R1: start without prerequisite
    req_cnt = 0;
    lo_addr = 0; hi_addr = 5; prereq_ok = 0; start = 1;
    @(negedge clk); start = 0;
    begin
      bit saw = 0;
      for (int i = 0; i < 10; i++) begin
        if (done || busy) saw = 1;
        @(negedge clk);
      end
      chk(!saw && req_cnt == 0, "R1 start ignored", req_cnt, 0);
    end

    // R2: inverted window
    req_cnt = 0;
    lo_addr = 10; hi_addr = 5; prereq_ok = 1; start = 1;
    @(negedge clk); start = 0;
    chk(done && range_err && !pass && !fail, "R2 range error", {done, range_err, pass, fail}, 12);
    @(negedge clk);
    chk(req_cnt == 0 && !busy, "R2 no access", req_cnt, 0);

    // directed corners
    run_test(0, 255, 0, 0);    // R3 full window, pattern wraps to 0
    run_test(7, 7, 0, 0);      // single location
    run_test(3, 4, 1, 0);      // R9 absent device, smallest window
    run_test(0, 255, 1, 0);    // R9 full window echo (last value 0)
    run_test(20, 60, 2, 20);   // R8 mismatch at first location
    run_test(20, 60, 2, 60);   // R8 mismatch at last location
    run_test(100, 100, 1, 0);  // R6 single location echo passes

    for (int n = 0; n < 10; n++) begin
      int unsigned lo = $urandom % 256;
      int unsigned hi = lo + ($urandom % (256 - lo));
      int unsigned m = $urandom % 3;
      int unsigned bad = lo + ($urandom % (hi - lo + 1));
      run_test(lo, hi, m, bad);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule